// File: doc/BRIEF.md
# Card Capacity CSD Field Encoder

This block turns a storage size, given as a count of 512-byte sectors, into the four 32-bit response words of a card-specific-data register. It picks one of two layouts. A device larger than 2 GiB gets the high-capacity layout, which has a 22-bit size field. Any smaller device gets the standard layout, which has a 12-bit mantissa and a 3-bit exponent. The computed fields are merged into fixed template words. A flag reports which layout was chosen, and a separate flag reports a size that the chosen layout cannot express.

A controller pulses `start_i` for one cycle and holds `sectors_i` valid in that cycle. For the standard layout, the exponent is found by halving the size one step per clock, so the time to a result depends on the size. The block pulses `done_o` when the words are ready. The words then stay unchanged until the next run completes. Any start that arrives while a run is in progress is ignored.

Top module: `csd_cap_encoder`

## Requirements
- R1: When `done_o` pulses, `high_cap_o` is 1 if the sector count accepted by that run exceeds 4194304 (more than 2^31 bytes). Otherwise it is 0.
- R2: In the high-capacity layout, the size field S is floor(sectors/1024) minus 1. S[15:0] is placed in word 1 bits 31:16 and S[21:16] in word 2 bits 5:0. These are merged into the template words, which are word 3 = 0x400E0032, word 2 = 0x5B590000, word 1 = 0x00007F80 and word 0 = 0x0A4040DF.
- R3: In the high-capacity layout, `range_err_o` is 1 when S does not fit in 22 bits. In that case the size bits are left at zero and only the template words are output.
- R4: In the standard layout, K starts as floor(sectors/2). K is halved while it exceeds 4096, and the number of halvings is n. The mantissa M is (K-1) mod 4096. M[11:2] is placed in word 2 bits 9:0, M[1:0] in word 1 bits 31:30, and n-2 in word 1 bits 17:15.
- R5: The standard-layout template words are word 3 = 0x00260032, word 2 = 0x5F5A8000, word 1 = 0x3EF84FFF and word 0 = 0x928040CB.
- R6: In the standard layout, `range_err_o` is 1 when n is below 2 or above 9. In that case the mantissa and exponent bits are left at zero.
- R7: `done_o` is high for exactly one cycle. It rises on the first clock edge after the edge that accepts `start_i` when the layout is high-capacity, and on the (n+2)th edge after it when the layout is standard.
- R8: The outputs `csd_w0_o` to `csd_w3_o`, `high_cap_o` and `range_err_o` change only in a cycle where `done_o` is high. `busy_o` is high from acceptance until done, and a `start_i` that arrives while `busy_o` is high has no effect on the result.
- R9: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins an encoding run when the block is idle |
| sectors_i | input | SECT_W | Storage size in 512-byte sectors, sampled together with start |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| high_cap_o | output | 1 | The high-capacity layout was selected |
| range_err_o | output | 1 | The size cannot be expressed in the selected layout |
| csd_w0_o | output | 32 | Response word 0 (bits 31:0) |
| csd_w1_o | output | 32 | Response word 1 (bits 63:32) |
| csd_w2_o | output | 32 | Response word 2 (bits 95:64) |
| csd_w3_o | output | 32 | Response word 3 (bits 127:96) |

## Verification
The high-capacity overflow error is the hardest case to reach. It needs a sector count wider than 32 bits, exactly one past 4194305×1024−1, so the bench uses a 34-bit size input and applies that value together with the largest count that still fits. A second hard case is the standard-layout boundary at exactly 2^31 bytes, where nine halvings give the largest exponent. The stimulus table covers this value and its neighbours on both sides of the layout switch. It also covers the too-small region, where n is 0 or 1. A start pulse is injected while a nine-step run is still busy, and the bench confirms that the run's result is not changed by it.

// File: rtl/csd_cap_pkg.sv
// Package: shared constants and types for the capacity encoder.
// Assumes nothing beyond the fixed template layouts used by both formats.
package csd_cap_pkg;

    typedef enum logic [1:0] {
        ENC_IDLE   = 2'd0,
        ENC_SHIFT  = 2'd1,
        ENC_FINISH = 2'd2
    } enc_state_t;

    localparam int HC_SIZE_W    = 22;
    localparam int STD_MANT_W   = 12;
    localparam int STD_EXP_W    = 3;
    localparam int KIB_LIMIT    = 4096;
    localparam int EXP_MIN      = 2;
    localparam int EXP_MAX      = 9;

    localparam logic [31:0] HC_W3  = 32'h400E0032;
    localparam logic [31:0] HC_W2  = 32'h5B590000;
    localparam logic [31:0] HC_W1  = 32'h00007F80;
    localparam logic [31:0] HC_W0  = 32'h0A4040DF;

    localparam logic [31:0] STD_W3 = 32'h00260032;
    localparam logic [31:0] STD_W2 = 32'h5F5A8000;
    localparam logic [31:0] STD_W1 = 32'h3EF84FFF;
    localparam logic [31:0] STD_W0 = 32'h928040CB;

endpackage

// File: rtl/csd_fmt_select.sv
// Module: csd_fmt_select
// Decides the layout from a sector count and computes the high-capacity
// size field together with its overflow flag. Purely combinational.
// Assumes SECT_W > 23, so that the 2 GiB threshold and the 22-bit field
// are both representable.
module csd_fmt_select #(
    parameter int SECT_W = 34
) (
    input  logic [SECT_W-1:0]               sect_i,
    output logic                            is_hc_o,
    output logic [csd_cap_pkg::HC_SIZE_W-1:0] hc_size_o,
    output logic                            hc_err_o
);
    import csd_cap_pkg::*;

    localparam int QUOT_SHIFT = 10;                       // 512 KiB / 512 B
    localparam logic [SECT_W-1:0] HC_THRESH = SECT_W'(1) << 22;

    logic [SECT_W-1:0] quot;
    logic [SECT_W-1:0] size_full;

    // Threshold compare and size field arithmetic.
    always_comb begin
        is_hc_o   = (sect_i > HC_THRESH);
        quot      = sect_i >> QUOT_SHIFT;
        size_full = quot - SECT_W'(1);
        hc_size_o = size_full[HC_SIZE_W-1:0];
        hc_err_o  = |size_full[SECT_W-1:HC_SIZE_W];
    end

endmodule

// File: rtl/csd_exp_search.sv
// Module: csd_exp_search
// Holds the KiB value and the shift count of the standard-layout exponent
// search. On a load it takes a new value and clears the count. On each step
// it halves the value and counts one shift, as long as the value is above the
// limit. Assumes that the controller steps only after a load.
module csd_exp_search #(
    parameter int KIB_W = 33,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [KIB_W-1:0] kib_i,
    input  logic             step_i,
    output logic             above_o,
    output logic [KIB_W-1:0] kib_o,
    output logic [CNT_W-1:0] cnt_o
);
    import csd_cap_pkg::*;

    localparam logic [KIB_W-1:0] LIMIT = KIB_W'(KIB_LIMIT);

    logic [KIB_W-1:0] kib_q;
    logic [CNT_W-1:0] cnt_q;

    // Compare against the limit that ends the loop.
    assign above_o = (kib_q > LIMIT);
    assign kib_o   = kib_q;
    assign cnt_o   = cnt_q;

    // Load, or halve and count one shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kib_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            kib_q <= kib_i;
            cnt_q <= '0;
        end else if (step_i && above_o) begin
            kib_q <= kib_q >> 1;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R4: every counted step makes the value strictly smaller
    a_r4_step_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && above_o && !load_i) |=> (kib_q < $past(kib_q)) && (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R4: a load restarts the count
    a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == '0));

endmodule

// File: rtl/csd_word_merge.sv
// Module: csd_word_merge
// Places the computed fields into the template words of the selected layout
// and works out the range error. Purely combinational. Assumes that kib_i
// is already at or below the loop limit when the standard layout is used.
module csd_word_merge #(
    parameter int KIB_W = 33,
    parameter int CNT_W = 7
) (
    input  logic                               is_hc_i,
    input  logic [csd_cap_pkg::HC_SIZE_W-1:0]  hc_size_i,
    input  logic                               hc_err_i,
    input  logic [KIB_W-1:0]                   kib_i,
    input  logic [CNT_W-1:0]                   cnt_i,
    output logic [31:0]                        w0_o,
    output logic [31:0]                        w1_o,
    output logic [31:0]                        w2_o,
    output logic [31:0]                        w3_o,
    output logic                               err_o
);
    import csd_cap_pkg::*;

    logic [KIB_W-1:0]      mant_full;
    logic [STD_MANT_W-1:0] mant;
    logic [CNT_W-1:0]      exp_full;
    logic [STD_EXP_W-1:0]  expo;
    logic                  std_err;

    // Mantissa, exponent and the standard-layout range check.
    always_comb begin
        mant_full = kib_i - KIB_W'(1);
        mant      = mant_full[STD_MANT_W-1:0];
        exp_full  = cnt_i - CNT_W'(EXP_MIN);
        expo      = exp_full[STD_EXP_W-1:0];
        std_err   = (cnt_i < CNT_W'(EXP_MIN)) || (cnt_i > CNT_W'(EXP_MAX));
    end

    // Select the template and place the fields unless they are out of range.
    always_comb begin
        if (is_hc_i) begin
            err_o = hc_err_i;
            w3_o  = HC_W3;
            w0_o  = HC_W0;
            w2_o  = HC_W2 | (hc_err_i ? 32'd0 : {26'd0, hc_size_i[21:16]});
            w1_o  = HC_W1 | (hc_err_i ? 32'd0 : {hc_size_i[15:0], 16'd0});
        end else begin
            err_o = std_err;
            w3_o  = STD_W3;
            w0_o  = STD_W0;
            w2_o  = STD_W2 | (std_err ? 32'd0 : {22'd0, mant[11:2]});
            w1_o  = STD_W1 | (std_err ? 32'd0 :
                              {mant[1:0], 12'd0, expo, 15'd0});
        end
    end

endmodule

// File: rtl/csd_cap_encoder.sv
// Module: csd_cap_encoder (top)
// Sequences one encoding run: it samples the sector count on start, runs the
// exponent search for the standard layout (one shift per clock), then
// registers the merged words and pulses done. Assumes that sectors_i is valid
// in the cycle where start_i is high. Starts that arrive while busy are dropped.
module csd_cap_encoder #(
    parameter int SECT_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SECT_W-1:0] sectors_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              high_cap_o,
    output logic              range_err_o,
    output logic [31:0]       csd_w0_o,
    output logic [31:0]       csd_w1_o,
    output logic [31:0]       csd_w2_o,
    output logic [31:0]       csd_w3_o
);
    import csd_cap_pkg::*;

    localparam int KIB_W = SECT_W - 1;
    localparam int CNT_W = $clog2(SECT_W) + 1;

    enc_state_t               state_q;
    logic                     hc_q;
    logic [HC_SIZE_W-1:0]     hc_size_q;
    logic                     hc_err_q;

    logic                     sel_hc;
    logic [HC_SIZE_W-1:0]     sel_size;
    logic                     sel_err;
    logic                     accept;
    logic                     step;
    logic                     above;
    logic [KIB_W-1:0]         kib;
    logic [CNT_W-1:0]         cnt;
    logic [31:0]              m_w0, m_w1, m_w2, m_w3;
    logic                     m_err;

    assign accept = start_i && (state_q == ENC_IDLE);
    assign step   = (state_q == ENC_SHIFT);
    assign busy_o = (state_q != ENC_IDLE);

    csd_fmt_select #(.SECT_W(SECT_W)) u_sel (
        .sect_i    (sectors_i),
        .is_hc_o   (sel_hc),
        .hc_size_o (sel_size),
        .hc_err_o  (sel_err)
    );

    csd_exp_search #(.KIB_W(KIB_W), .CNT_W(CNT_W)) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .kib_i   (sectors_i[SECT_W-1:1]),
        .step_i  (step),
        .above_o (above),
        .kib_o   (kib),
        .cnt_o   (cnt)
    );

    csd_word_merge #(.KIB_W(KIB_W), .CNT_W(CNT_W)) u_merge (
        .is_hc_i   (hc_q),
        .hc_size_i (hc_size_q),
        .hc_err_i  (hc_err_q),
        .kib_i     (kib),
        .cnt_i     (cnt),
        .w0_o      (m_w0),
        .w1_o      (m_w1),
        .w2_o      (m_w2),
        .w3_o      (m_w3),
        .err_o     (m_err)
    );

    // Run sequencing: idle, shifting, finishing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENC_IDLE;
        end else begin
            unique case (state_q)
                ENC_IDLE:   if (accept) state_q <= sel_hc ? ENC_FINISH : ENC_SHIFT;
                ENC_SHIFT:  if (!above) state_q <= ENC_FINISH;
                ENC_FINISH: state_q <= ENC_IDLE;
                default:    state_q <= ENC_IDLE;
            endcase
        end
    end

    // Capture the layout decision and the high-capacity field at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q      <= 1'b0;
            hc_size_q <= '0;
            hc_err_q  <= 1'b0;
        end else if (accept) begin
            hc_q      <= sel_hc;
            hc_size_q <= sel_size;
            hc_err_q  <= sel_err;
        end
    end

    // Register the result and pulse done at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            high_cap_o  <= 1'b0;
            range_err_o <= 1'b0;
            csd_w0_o    <= '0;
            csd_w1_o    <= '0;
            csd_w2_o    <= '0;
            csd_w3_o    <= '0;
        end else begin
            done_o <= (state_q == ENC_FINISH);
            if (state_q == ENC_FINISH) begin
                high_cap_o  <= hc_q;
                range_err_o <= m_err;
                csd_w0_o    <= m_w0;
                csd_w1_o    <= m_w1;
                csd_w2_o    <= m_w2;
                csd_w3_o    <= m_w3;
            end
        end
    end

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7/R8: the block is idle in the cycle where done is high
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: results hold outside the done cycle
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(csd_w0_o) && $stable(csd_w1_o) && $stable(csd_w2_o)
                     && $stable(csd_w3_o) && $stable(high_cap_o) && $stable(range_err_o)));

    // R2: high-capacity fixed words
    a_r2_hc_template: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && high_cap_o) |-> (csd_w3_o == HC_W3) && (csd_w0_o == HC_W0)
                                   && (csd_w1_o[15:0] == HC_W1[15:0]));

    // R5: standard fixed words
    a_r5_std_template: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !high_cap_o) |-> (csd_w3_o == STD_W3) && (csd_w0_o == STD_W0));

    // R6: a standard range error leaves the fields zero
    a_r6_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !high_cap_o && range_err_o) |->
            (csd_w2_o == STD_W2) && (csd_w1_o == STD_W1));

endmodule

// File: tb/csd_cap_encoder_tb.sv
`timescale 1ns/1ps
module csd_cap_encoder_tb;

    localparam int SECT_W = 34;
    localparam int NVEC   = 16;

    // Stimulus table; the expected results come from the requirement model below.
    localparam logic [SECT_W-1:0] VEC [NVEC] = '{
        34'd0, 34'd1, 34'd16384, 34'd18432, 34'd20000, 34'd1000000,
        34'd4194303, 34'd4194304, 34'd4194305, 34'd8388608, 34'd67108864,
        34'd4294967295, 34'd4294968319, 34'd4294968320, 34'h3_FFFF_FFFF,
        34'd9000
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [SECT_W-1:0] sectors_i = '0;
    logic              busy_o, done_o, high_cap_o, range_err_o;
    logic [31:0]       csd_w0_o, csd_w1_o, csd_w2_o, csd_w3_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    csd_cap_encoder #(.SECT_W(SECT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sectors_i(sectors_i),
        .busy_o(busy_o), .done_o(done_o), .high_cap_o(high_cap_o),
        .range_err_o(range_err_o), .csd_w0_o(csd_w0_o), .csd_w1_o(csd_w1_o),
        .csd_w2_o(csd_w2_o), .csd_w3_o(csd_w3_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of R1-R6 plus the R7 latency.
    task automatic model(input logic [SECT_W-1:0] s,
                         output logic [31:0] w0, output logic [31:0] w1,
                         output logic [31:0] w2, output logic [31:0] w3,
                         output logic hc, output logic er, output int lat);
        longint q, sz, k;
        int n;
        logic [11:0] m;
        if (s > 34'd4194304) begin
            hc = 1'b1; lat = 1;
            q = longint'(s) / 1024; sz = q - 1;
            er = (sz >= 64'd4194304);
            w3 = 32'h400E0032; w0 = 32'h0A4040DF;
            w2 = 32'h5B590000; w1 = 32'h00007F80;
            if (!er) begin
                w2 = w2 | 32'(sz >> 16);
                w1 = w1 | (32'(sz & 64'hFFFF) << 16);
            end
        end else begin
            hc = 1'b0;
            k = longint'(s) / 2; n = 0;
            while (k > 4096) begin k = k >> 1; n++; end
            lat = n + 2;
            m = 12'(k - 1);
            er = (n < 2) || (n > 9);
            w3 = 32'h00260032; w0 = 32'h928040CB;
            w2 = 32'h5F5A8000; w1 = 32'h3EF84FFF;
            if (!er) begin
                w2 = w2 | {22'd0, m[11:2]};
                w1 = w1 | {m[1:0], 30'd0} | (32'(n - 2) << 15);
            end
        end
    endtask

    // Pulse start, count edges to done, compare everything.
    task automatic run_case(input logic [SECT_W-1:0] s);
        logic [31:0] e0, e1, e2, e3;
        logic ehc, eer;
        int elat;
        int edges;
        model(s, e0, e1, e2, e3, ehc, eer, elat);
        @(negedge clk);
        start_i = 1'b1; sectors_i = s;
        @(posedge clk);
        #1 start_i = 1'b0; sectors_i = '0;
        edges = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            edges++;
            if (done_o) break;
        end
        check("R7 latency", 64'(edges), 64'(elat));
        check("R1 high_cap", 64'(high_cap_o), 64'(ehc));
        check(ehc ? "R3 range_err" : "R6 range_err", 64'(range_err_o), 64'(eer));
        check(ehc ? "R2 word0" : "R5 word0", 64'(csd_w0_o), 64'(e0));
        check(ehc ? "R2 word1" : "R4 word1", 64'(csd_w1_o), 64'(e1));
        check(ehc ? "R2 word2" : "R4 word2", 64'(csd_w2_o), 64'(e2));
        check(ehc ? "R2 word3" : "R5 word3", 64'(csd_w3_o), 64'(e3));
        @(posedge clk); #1;
        check("R7 done single", 64'(done_o), 64'd0);
    endtask

    initial begin
        logic [31:0] h0, h1, h2, h3;
        logic [31:0] e0, e1, e2, e3;
        logic ehc, eer;
        int elat;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9 done", 64'(done_o), 64'd0);
        check("R9 busy", 64'(busy_o), 64'd0);
        check("R9 words", {csd_w3_o, csd_w0_o} | {csd_w1_o, csd_w2_o}, 64'd0);
        check("R9 flags", 64'({high_cap_o, range_err_o}), 64'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) run_case(VEC[v]);

        // R8: outputs hold while idle, even when sectors_i moves
        h0 = csd_w0_o; h1 = csd_w1_o; h2 = csd_w2_o; h3 = csd_w3_o;
        @(negedge clk) sectors_i = 34'd123456;
        repeat (6) @(posedge clk);
        #1;
        check("R8 hold", {h1, h2} ^ {csd_w1_o, csd_w2_o}, 64'd0);
        check("R8 hold", {h0, h3} ^ {csd_w0_o, csd_w3_o}, 64'd0);

        // R8: start during a nine-step run is ignored
        model(34'd4194304, e0, e1, e2, e3, ehc, eer, elat);
        @(negedge clk);
        start_i = 1'b1; sectors_i = 34'd4194304;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 busy", 64'(busy_o), 64'd1);
        repeat (2) @(negedge clk);
        start_i = 1'b1; sectors_i = 34'd18432;
        @(negedge clk);
        start_i = 1'b0; sectors_i = '0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (done_o) break;
        end
        check("R8 ignored start w1", 64'(csd_w1_o), 64'(e1));
        check("R8 ignored start w2", 64'(csd_w2_o), 64'(e2));
        repeat (3) @(posedge clk);
        #1;
        check("R8 no second run", 64'(busy_o), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule